// File: doc/BRIEF.md
# Lockable Countdown Watchdog

This block is a down-counting watchdog timer behind a small word-addressed register port. Software loads a start value and an alarm threshold, then sets the enable bit. Setting the enable bit copies the start value into the counter. From then on, the counter drops by one on every clock cycle in which the `tick` input is high. That input stands in for the slow always-on clock, so that one fast clock can drive the whole block.

When the count steps down onto the threshold, a sticky interrupt flag rises. When the count steps down onto zero, a one-cycle system reset request is issued and the counter parks at zero. A magic-word key register guards every other register against writes, so stray or hostile code cannot silence the watchdog. Clearing the enable bit wipes the whole block back to its reset state, and that includes re-locking the key.

Register map (word addresses on `addr`): 0 = key, 1 = control (bit 0 enable, bit 1 alarm flag), 2 = start value, 3 = live count (read-only), 4 = alarm threshold. All other addresses read as zero.

Top module: `wdog_lockable`

## Requirements
- R1: After `rst_n` is released, the block is locked, the enable and alarm bits are 0, the start value, threshold and count all read 0, and `irq` and `rst_req` are low.
- R2: A write of 0x15CC5A51 to address 0 unlocks the block from the next cycle on. While the block is unlocked, bit 0 of address 0 reads 1.
- R3: A write of any other value to address 0 locks the block, and bit 0 of address 0 then reads 0. Writes to address 0 are accepted in either lock state. While the block is locked, writes to every other address have no effect.
- R4: An unlocked write to address 1 with bit 0 set, made while the block is disabled, loads the start value into the count in the next cycle, and the count does not also step down in that cycle. The same write made while the block is already enabled leaves the count unchanged.
- R5: While the block is enabled, the count falls by exactly one in each cycle in which `tick` is high and the count is nonzero. It holds its value in each cycle in which `tick` is low.
- R6: `irq` rises in the same cycle in which the count steps down onto the threshold value, and it then stays high. An unlocked write to address 1 with bit 1 set clears it. The same write made while locked leaves it set.
- R7: `rst_req` is high for exactly one cycle: the first cycle in which a step-down leaves the count at 0. The count then stays at 0 and no further request follows.
- R8: An unlocked write to address 1 with bit 0 clear returns the start value, threshold, count, alarm and enable bits to 0 and locks the block.
- R9: Enabling with a start value of 0 leaves the count at 0 and never raises `rst_req`.
- R10: Reads of every register are valid in both lock states. Address 3 is read-only, so writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-step enable, one pulse per slow-clock period |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register word address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| irq | output | 1 | Sticky alarm interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Every register write and every tick takes effect at the single clock edge that samples it. The count, the lock bit, `irq` and `rst_req` therefore all show their new values one cycle after the stimulus, and `rdata` follows `addr` with no delay. The bench drives stimulus on the falling edge and checks outputs on the next falling edge, one edge later. For register reads it changes `addr` and samples a nanosecond later, inside the same low phase. The sweep runs through the start values 0 to 6 and the thresholds 0 to 6, with both a steady tick and a gapped tick pattern. An arithmetic model steps alongside the design and predicts the count, `irq` and `rst_req` for every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        A_KEY   = 3'd0,
        A_CTRL  = 3'd1,
        A_LOAD  = 3'd2,
        A_COUNT = 3'd3,
        A_THR   = 3'd4
    } reg_addr_e;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_ALM_BIT = 1;
endpackage

// File: rtl/wdog_keygate.sv
module wdog_keygate #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] KEY = W'(32'h15CC5A51)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         key_wr,
    input  logic [W-1:0] key_val,
    input  logic         wipe,
    output logic         open_o
);
    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (wipe) begin
            open_d = 1'b0;
        end else if (key_wr) begin
            open_d = (key_val == KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else begin
            open_q <= open_d;
        end
    end

    assign open_o = open_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         wipe,
    input  logic         step,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] thr,
    output logic [W-1:0] count_o,
    output logic         alarm_evt_o,
    output logic         expire_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         expire;
    } cnt_st_t;

    cnt_st_t      st_d, st_q;
    logic [W-1:0] dec_val;

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        dec_val     = st_q.cnt - W'(1);
        alarm_evt_o = 1'b0;
        if (wipe) begin
            st_d.cnt = '0;
        end else if (start) begin
            st_d.cnt = load_val;
        end else if (step && (st_q.cnt != '0)) begin
            st_d.cnt    = dec_val;
            alarm_evt_o = (dec_val == thr);
            st_d.expire = (dec_val == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.cnt;
    assign expire_o = st_q.expire;
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
    import wdog_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [REG_AW-1:0] addr,
    input  logic              unlocked,
    input  logic              en,
    input  logic              alarm,
    input  logic [W-1:0]      load,
    input  logic [W-1:0]      count,
    input  logic [W-1:0]      thr,
    output logic [W-1:0]      rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            A_KEY:   rdata[0] = unlocked;
            A_CTRL: begin
                rdata[CTRL_EN_BIT]  = en;
                rdata[CTRL_ALM_BIT] = alarm;
            end
            A_LOAD:  rdata = load;
            A_COUNT: rdata = count;
            A_THR:   rdata = thr;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter logic [CNT_W-1:0] UNLOCK_KEY = CNT_W'(32'h15CC5A51)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq,
    output logic              rst_req
);
    typedef struct packed {
        logic             en;
        logic             alarm;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] thr;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic             unlocked;
    logic             wr_ok, key_wr, ctrl_wr, wipe, start;
    logic             alarm_evt, expire;
    logic [CNT_W-1:0] count;

    always_comb begin
        wr_ok   = wr_en && unlocked;
        key_wr  = wr_en && (addr == A_KEY);
        ctrl_wr = wr_ok && (addr == A_CTRL);
        wipe    = ctrl_wr && !wdata[CTRL_EN_BIT];
        start   = ctrl_wr && wdata[CTRL_EN_BIT] && !cfg_q.en;

        cfg_d = cfg_q;
        if (wipe) begin
            cfg_d = '0;
        end else begin
            if (start) cfg_d.en = 1'b1;
            if (wr_ok && (addr == A_LOAD)) cfg_d.load = wdata;
            if (wr_ok && (addr == A_THR))  cfg_d.thr  = wdata;
            if (ctrl_wr && wdata[CTRL_ALM_BIT]) cfg_d.alarm = 1'b0;
            if (alarm_evt) cfg_d.alarm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    wdog_keygate #(.W(CNT_W), .KEY(UNLOCK_KEY)) key_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_val (wdata),
        .wipe    (wipe),
        .open_o  (unlocked)
    );

    wdog_counter #(.W(CNT_W)) cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .wipe        (wipe),
        .step        (cfg_q.en && tick),
        .load_val    (cfg_q.load),
        .thr         (cfg_q.thr),
        .count_o     (count),
        .alarm_evt_o (alarm_evt),
        .expire_o    (expire)
    );

    wdog_rdmux #(.W(CNT_W)) rd_i (
        .addr     (addr),
        .unlocked (unlocked),
        .en       (cfg_q.en),
        .alarm    (cfg_q.alarm),
        .load     (cfg_q.load),
        .count    (count),
        .thr      (cfg_q.thr),
        .rdata    (rdata)
    );

    assign irq     = cfg_q.alarm;
    assign rst_req = expire;
endmodule

// File: rtl/wdog_lockable_chk.sv
module wdog_lockable_chk #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] KEY = W'(32'h15CC5A51)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         wr_en,
    input logic [2:0]   addr,
    input logic [W-1:0] wdata,
    input logic         unlocked,
    input logic         en,
    input logic [W-1:0] load,
    input logic [W-1:0] count,
    input logic         irq,
    input logic         rst_req
);
    assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && wdata == KEY) |=> unlocked);

    assert_locked_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && wr_en && addr == 3'd2) |=> $stable(load));

    assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && !wr_en) |=> $stable(count));

    assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && count != '0 && !(wr_en && addr == 3'd1))
        |=> (count == $past(count) - W'(1)));

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en && addr == 3'd1 && unlocked));

    assert_req_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_req_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (count == '0));
endmodule

bind wdog_lockable wdog_lockable_chk #(.W(CNT_W), .KEY(UNLOCK_KEY)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .unlocked (unlocked),
    .en       (cfg_q.en),
    .load     (cfg_q.load),
    .count    (count),
    .irq      (irq),
    .rst_req  (rst_req)
);

// File: tb/wdog_lockable_tb.sv
module wdog_lockable_tb_top;
    localparam logic [31:0] MAGIC = 32'h15CC5A51;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rst_req;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_lockable dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd("R1 key", 3'd0, 0);
        rd("R1 ctrl", 3'd1, 0);
        rd("R1 load", 3'd2, 0);
        rd("R1 count", 3'd3, 0);
        rd("R1 thr", 3'd4, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);

        // R3/R10 locked writes ignored, reads still valid
        wr(3'd2, 32'd9);
        rd("R3 locked load write", 3'd2, 0);
        wr(3'd1, 32'd1);
        rd("R3 locked enable write", 3'd1, 0);

        // R2 unlock
        wr(3'd0, MAGIC);
        rd("R2 key reads open", 3'd0, 1);
        wr(3'd2, 32'd9);
        rd("R10 load readback", 3'd2, 9);
        wr(3'd3, 32'd77);
        rd("R10 count read-only", 3'd3, 0);

        // R3 wrong key relocks
        wr(3'd0, MAGIC ^ 32'h1);
        rd("R3 key reads locked", 3'd0, 0);
        wr(3'd2, 32'd3);
        rd("R3 relocked load write", 3'd2, 9);
        wr(3'd0, 32'h0);
        rd("R3 key write while locked", 3'd0, 0);

        // R4 enable with tick high during the write: no extra step
        wr(3'd0, MAGIC);
        wr(3'd4, 32'd100);
        tick = 1'b1;
        wr(3'd1, 32'd1);
        tick = 1'b0;
        rd("R4 loaded on enable", 3'd3, 9);
        run_ticks(3);
        rd("R5 three ticks", 3'd3, 6);
        repeat (4) @(negedge clk);
        rd("R5 hold without tick", 3'd3, 6);
        wr(3'd1, 32'd1);
        rd("R4 re-enable no reload", 3'd3, 6);

        // R6 alarm set, locked clear ignored, unlocked clear works
        wr(3'd4, 32'd4);
        run_ticks(2);
        chk("R6 irq at threshold", irq, 1);
        run_ticks(1);
        chk("R6 irq sticky", irq, 1);
        wr(3'd0, 32'h5);
        wr(3'd1, 32'd3);
        chk("R6 locked clear ignored", irq, 1);
        wr(3'd0, MAGIC);
        wr(3'd1, 32'd3);
        chk("R6 unlocked clear", irq, 0);
        rd("R6 still enabled", 3'd1, 1);

        // R8 wipe
        wr(3'd1, 32'd0);
        rd("R8 ctrl", 3'd1, 0);
        rd("R8 load", 3'd2, 0);
        rd("R8 thr", 3'd4, 0);
        rd("R8 count", 3'd3, 0);
        rd("R8 relocked", 3'd0, 0);
        chk("R8 irq", irq, 0);

        // Sweep: start 0..6, threshold 0..6, steady and gapped ticks
        for (int ld = 0; ld < 7; ld++) begin
            for (int th = 0; th < 7; th++) begin
                for (int p = 0; p < 2; p++) begin
                    int  exp_cnt;
                    bit  exp_irq;
                    bit  exp_rst;
                    bit  t;
                    wr(3'd0, MAGIC);
                    wr(3'd2, 32'(ld));
                    wr(3'd4, 32'(th));
                    wr(3'd1, 32'd1);
                    addr = 3'd3;
                    exp_cnt = ld;
                    exp_irq = 1'b0;
                    for (int c = 0; c < 3 * ld + 4; c++) begin
                        t = (p == 0) ? 1'b1 : ((c % 3) != 1);
                        tick = t;
                        @(negedge clk);
                        exp_rst = 1'b0;
                        if (t && exp_cnt != 0) begin
                            exp_cnt--;
                            if (exp_cnt == th) exp_irq = 1'b1;
                            if (exp_cnt == 0) exp_rst = 1'b1;
                        end
                        chk("R5 sweep count", rdata, 32'(exp_cnt));
                        chk("R6 sweep irq", irq, exp_irq);
                        if (ld == 0) chk("R9 zero start no request", rst_req, 0);
                        else chk("R7 sweep rst_req", rst_req, exp_rst);
                    end
                    tick = 1'b0;
                    wr(3'd1, 32'd0);
                    rd("R8 sweep wipe count", 3'd3, 0);
                    chk("R8 sweep wipe irq", irq, 0);
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule